// File: doc/BRIEF.md
# Flag-Generating Shift Unit

This unit shifts an 8-, 16- or 32-bit operand left, logically right or arithmetically right by a count of 0 to 31. Alongside the shifted value it produces the six status flags that a legacy-style integer pipeline keeps: carry, parity, auxiliary carry, zero, sign and overflow. It also raises a write enable that tells the flag register whether to take the new flags. The shift and the flag logic are combinational. A parameter selects whether a register stage sits on the outputs.

A caller drives the operand, the count, a width select, an operation select and the current flag values every cycle. A count of zero acts as a no-op and hands the incoming flags straight back. Overflow is defined only for a count of one; for any other count the incoming overflow bit passes through unchanged. Carry is always the last bit pushed past the edge of the selected width.

Top module: `shf_unit`

## Requirements
- R1: Width select 2'b00 picks 8 bits, 2'b01 picks 16, and 2'b10 or 2'b11 picks 32. Only the low bits of `operand_i` for that width are used, and `result_o` is zero above the selected width.
- R2: When `count_i` is zero, `result_o` is the width-masked operand, `flags_o` equals `flags_i` and `flag_we_o` is 0.
- R3: Operation 2'b00 shifts left. Carry is the source bit at position (width - count). A count above the width gives a zero result with carry 0.
- R4: Operation 2'b01 (and the spare code 2'b11) shifts right logically. Carry is source bit (count - 1), or 0 when the count exceeds the width.
- R5: Operation 2'b10 shifts right arithmetically, copying the top bit of the width into every vacated position. Carry is source bit (count - 1), or the top bit when the count exceeds the width.
- R6: With a count of one, overflow is set as follows: arithmetic right clears it, logical right takes the source top bit, and left takes the exclusive-or of the two top source bits.
- R7: With a count of two or more, overflow equals the incoming overflow bit.
- R8: Every nonzero count sets auxiliary carry to 1 and drives `flag_we_o` to 1.
- R9: Sign is the top bit of the result within the width. Zero is set when the width-masked result is zero. Parity is set when the low 8 result bits hold an even number of ones.
- R10: With the register stage enabled (the default), outputs appear one clock after the inputs, and reset drives every output to zero. Flag bit order on `flags_i`/`flags_o`: [0] carry, [1] parity, [2] auxiliary, [3] zero, [4] sign, [5] overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation select: left, logical right, arithmetic right |
| width_i | input | 2 | Operand width select |
| count_i | input | 5 | Shift count |
| operand_i | input | 32 | Source operand |
| flags_i | input | 6 | Current flag values |
| result_o | output | 32 | Shifted result, zero-extended |
| flags_o | output | 6 | Updated flag values |
| flag_we_o | output | 1 | Flag write enable |

## Verification
Two behaviours can act in the same cycle: the count-of-one overflow rule and the carry taken from the far end of the operand. The bench provokes this with a count of one at every width and operation on random operands, and judges overflow, carry and result together against a bit-serial reference model. The bench also sends back-to-back operations that alternate between zero and nonzero counts with changing incoming flags. This shows that the pass-through of a zero count and the overflow hold at larger counts never draw on flag values left over from an earlier operation.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [1:0] {
      SHF_LEFT   = 2'b00,
      SHF_LRIGHT = 2'b01,
      SHF_ARIGHT = 2'b10,
      SHF_SPARE  = 2'b11
   } shf_op_e;

   localparam int FLAG_W  = 6;
   localparam int FL_CARRY = 0;
   localparam int FL_PAR   = 1;
   localparam int FL_AUX   = 2;
   localparam int FL_ZERO  = 3;
   localparam int FL_SIGN  = 4;
   localparam int FL_OVF   = 5;
endpackage

// File: rtl/shf_datapath.sv
module shf_datapath
   import shf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 5,
   parameter int NUM_LANES = 3,
   parameter int LANE_IW   = 2
) (
   input  logic [1:0]          op_i,
   input  logic [1:0]          width_i,
   input  logic [CNT_W-1:0]    count_i,
   input  logic [DATA_W-1:0]   operand_i,
   output logic [DATA_W-1:0]   res_o,
   output logic                carry_o,
   output logic                ovf_one_o,
   output logic [LANE_IW-1:0]  lane_o
);
   logic [NUM_LANES-1:0][DATA_W-1:0] lane_mask;
   logic [NUM_LANES-1:0]             lane_msb;
   logic [NUM_LANES-1:0]             lane_nxt;
   logic [NUM_LANES-1:0]             lane_lc;

   logic [LANE_IW-1:0]   lane;
   logic [DATA_W-1:0]    wmask;
   logic [DATA_W-1:0]    x;
   logic                 msb;
   logic                 nxt;
   logic [2*DATA_W-1:0]  ext;
   logic [CNT_W-1:0]     cm1;
   logic [DATA_W:0]      rsh;
   logic [DATA_W:0]      lsh;
   logic [DATA_W-1:0]    rres;
   logic [DATA_W-1:0]    lres;

   assign lane = (width_i >= 2'(NUM_LANES)) ? LANE_IW'(NUM_LANES-1) : LANE_IW'(width_i);
   assign lane_o = lane;

   assign x   = operand_i & wmask;
   assign lsh = {1'b0, x} << count_i;

   genvar k;
   generate
      for (k = 0; k < NUM_LANES; k++) begin : g_lane
         localparam int LW = 8 << k;
         assign lane_mask[k] = ~(({DATA_W{1'b1}} << (LW-1)) << 1);
         assign lane_msb[k]  = operand_i[LW-1];
         assign lane_nxt[k]  = operand_i[LW-2];
         assign lane_lc[k]   = lsh[LW];
      end
   endgenerate

   assign wmask = lane_mask[lane];
   assign msb   = lane_msb[lane];
   assign nxt   = lane_nxt[lane];

   // sign fill above the width only for arithmetic right shift
   assign ext = {{DATA_W{1'b0}}, x} |
                (((op_i == SHF_ARIGHT) && msb) ? ~{{DATA_W{1'b0}}, wmask} : '0);
   assign cm1  = count_i - 1'b1;
   assign rsh  = (DATA_W+1)'(ext >> cm1);
   assign rres = DATA_W'(rsh >> 1) & wmask;
   assign lres = DATA_W'(lsh) & wmask;

   always_comb begin
      res_o     = x;
      carry_o   = 1'b0;
      ovf_one_o = 1'b0;
      if (count_i != '0) begin
         if (op_i == SHF_LEFT) begin
            res_o     = lres;
            carry_o   = lane_lc[lane];
            ovf_one_o = msb ^ nxt;
         end else begin
            res_o     = rres;
            carry_o   = rsh[0];
            ovf_one_o = (op_i == SHF_ARIGHT) ? 1'b0 : msb;
         end
      end
   end
endmodule

// File: rtl/shf_flags.sv
module shf_flags
   import shf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 5,
   parameter int NUM_LANES = 3,
   parameter int LANE_IW   = 2
) (
   input  logic [DATA_W-1:0]   res_i,
   input  logic [LANE_IW-1:0]  lane_i,
   input  logic [CNT_W-1:0]    count_i,
   input  logic                carry_i,
   input  logic                ovf_one_i,
   input  logic [FLAG_W-1:0]   flags_i,
   output logic [FLAG_W-1:0]   flags_o,
   output logic                we_o
);
   logic [NUM_LANES-1:0] lane_sign;

   genvar k;
   generate
      for (k = 0; k < NUM_LANES; k++) begin : g_sign
         assign lane_sign[k] = res_i[(8<<k)-1];
      end
   endgenerate

   always_comb begin
      flags_o = flags_i;
      we_o    = 1'b0;
      if (count_i != '0) begin
         we_o              = 1'b1;
         flags_o[FL_CARRY] = carry_i;
         flags_o[FL_PAR]   = ~^res_i[7:0];
         flags_o[FL_AUX]   = 1'b1;
         flags_o[FL_ZERO]  = (res_i == '0);
         flags_o[FL_SIGN]  = lane_sign[lane_i];
         if (count_i == CNT_W'(1))
            flags_o[FL_OVF] = ovf_one_i;
      end
   end
endmodule

// File: rtl/shf_out_stage.sv
module shf_out_stage
   import shf_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  res_i,
   input  logic [FLAG_W-1:0]  flags_i,
   input  logic               we_i,
   output logic [DATA_W-1:0]  res_o,
   output logic [FLAG_W-1:0]  flags_o,
   output logic               we_o
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_o   <= '0;
               flags_o <= '0;
               we_o    <= 1'b0;
            end else begin
               res_o   <= res_i;
               flags_o <= flags_i;
               we_o    <= we_i;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign res_o   = res_i;
         assign flags_o = flags_i;
         assign we_o    = we_i;
      end
   endgenerate
endmodule

// File: rtl/shf_unit.sv
module shf_unit
   import shf_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int CNT_W     = $clog2(DATA_W),
   localparam int NUM_LANES = $clog2(DATA_W/8) + 1,
   localparam int LANE_IW   = $clog2(NUM_LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         op_i,
   input  logic [1:0]         width_i,
   input  logic [CNT_W-1:0]   count_i,
   input  logic [DATA_W-1:0]  operand_i,
   input  logic [FLAG_W-1:0]  flags_i,
   output logic [DATA_W-1:0]  result_o,
   output logic [FLAG_W-1:0]  flags_o,
   output logic               flag_we_o
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("shf_unit supports a 32-bit datapath only");
      end
   endgenerate

   logic [DATA_W-1:0]  dp_res;
   logic               dp_carry;
   logic               dp_ovf;
   logic [LANE_IW-1:0] dp_lane;
   logic [FLAG_W-1:0]  fg_flags;
   logic               fg_we;

   shf_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_LANES(NUM_LANES), .LANE_IW(LANE_IW)) u_dp (
      .op_i(op_i), .width_i(width_i), .count_i(count_i), .operand_i(operand_i),
      .res_o(dp_res), .carry_o(dp_carry), .ovf_one_o(dp_ovf), .lane_o(dp_lane)
   );

   shf_flags #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_LANES(NUM_LANES), .LANE_IW(LANE_IW)) u_fg (
      .res_i(dp_res), .lane_i(dp_lane), .count_i(count_i), .carry_i(dp_carry),
      .ovf_one_i(dp_ovf), .flags_i(flags_i), .flags_o(fg_flags), .we_o(fg_we)
   );

   shf_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n), .res_i(dp_res), .flags_i(fg_flags), .we_i(fg_we),
      .res_o(result_o), .flags_o(flags_o), .we_o(flag_we_o)
   );

   generate
      if (REG_OUT) begin : g_chk
         logic armed;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) armed <= 1'b0;
            else        armed <= 1'b1;
         end

         assert_zero_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(count_i) == '0) |-> (flags_o == $past(flags_i) && !flag_we_o));

         assert_sar_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(count_i) == CNT_W'(1) && $past(op_i) == SHF_ARIGHT) |-> !flags_o[FL_OVF]);

         assert_ovf_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(count_i) > CNT_W'(1)) |-> (flags_o[FL_OVF] == $past(flags_i[FL_OVF])));

         assert_aux_and_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(count_i) != '0) |-> (flag_we_o && flags_o[FL_AUX]));

         assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
            flag_we_o |-> (flags_o[FL_ZERO] == (result_o == '0)));
      end
   endgenerate
endmodule

// File: tb/shf_unit_tb.sv
module shf_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_i = '0;
   logic [1:0]  width_i = '0;
   logic [4:0]  count_i = '0;
   logic [31:0] operand_i = '0;
   logic [5:0]  flags_i = '0;
   logic [31:0] result_o;
   logic [5:0]  flags_o;
   logic        flag_we_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #5 clk = ~clk;

   shf_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .width_i(width_i), .count_i(count_i),
      .operand_i(operand_i), .flags_i(flags_i), .result_o(result_o),
      .flags_o(flags_o), .flag_we_o(flag_we_o)
   );

   // bit-serial reference: returns {we, flags[5:0], result[31:0]}
   function automatic logic [38:0] ref_fn(input logic [1:0] op, input logic [1:0] w,
                                          input logic [4:0] c, input logic [31:0] xi,
                                          input logic [5:0] fi);
      int W;
      logic [31:0] x, v;
      logic cf, of, top;
      W = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
      x = 32'h0;
      for (int i = 0; i < W; i++) x[i] = xi[i];
      if (c == 0) return {1'b0, fi, x};
      v = x; cf = 1'b0; top = x[W-1];
      for (int i = 0; i < c; i++) begin
         if (op == 2'd0) begin
            cf = v[W-1];
            v = v << 1;
            if (W < 32) v[W] = 1'b0;
         end else begin
            cf = v[0];
            v = v >> 1;
            if (op == 2'd2) v[W-1] = top;
         end
      end
      of = fi[5];
      if (c == 1) of = (op == 2'd2) ? 1'b0 : (op == 2'd0) ? (x[W-1] ^ x[W-2]) : x[W-1];
      return {1'b1, of, v[W-1], (v == 32'h0), 1'b1, ~^v[7:0], cf, v};
   endfunction

   task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual we=%0b flags=%06b res=%08h expected we=%0b flags=%06b res=%08h",
                  tag, act[38], act[37:32], act[31:0], exp[38], exp[37:32], exp[31:0]);
      end
   endtask

   task automatic run_op(input string tag, input logic [1:0] op, input logic [1:0] w,
                         input logic [4:0] c, input logic [31:0] x, input logic [5:0] f);
      @(negedge clk);
      op_i = op; width_i = w; count_i = c; operand_i = x; flags_i = f;
      @(negedge clk);
      check(tag, {flag_we_o, flags_o, result_o}, ref_fn(op, w, c, x, f));
   endtask

   function automatic string tag_for(input logic [1:0] op, input logic [4:0] c);
      if (c == 0) return "R2";
      if (c == 1) return "R6";
      if (op == 2'd0) return "R3";
      if (op == 2'd2) return "R5";
      return "R4";
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_1234);
      repeat (2) @(negedge clk);
      // R10: reset state of the registered outputs
      check("R10", {flag_we_o, flags_o, result_o}, 39'h0);
      rst_n = 1'b1;

      // R1: junk above the selected width is ignored
      run_op("R1", 2'd1, 2'd0, 5'd1, 32'hFFFF_FF81, 6'b000000);
      run_op("R1", 2'd0, 2'd1, 5'd3, 32'hABCD_9001, 6'b111111);
      run_op("R1", 2'd2, 2'd3, 5'd4, 32'h8000_0010, 6'b000000);
      // R3: left beyond width, and exactly the width
      run_op("R3", 2'd0, 2'd0, 5'd9, 32'h0000_00FF, 6'b000001);
      run_op("R3", 2'd0, 2'd0, 5'd8, 32'h0000_0001, 6'b000000);
      run_op("R3", 2'd0, 2'd1, 5'd17, 32'h0000_FFFF, 6'b000000);
      // R4 / R5: right beyond width
      run_op("R4", 2'd1, 2'd1, 5'd20, 32'h0000_FFFF, 6'b000000);
      run_op("R5", 2'd2, 2'd0, 5'd31, 32'h0000_0080, 6'b000000);
      run_op("R5", 2'd2, 2'd2, 5'd31, 32'h8000_0000, 6'b000000);
      run_op("R4", 2'd3, 2'd2, 5'd5, 32'hF000_0010, 6'b000000);
      // R6: count of one on each op
      run_op("R6", 2'd0, 2'd2, 5'd1, 32'h4000_0000, 6'b000000);
      run_op("R6", 2'd1, 2'd2, 5'd1, 32'h8000_0001, 6'b000000);
      run_op("R6", 2'd2, 2'd1, 5'd1, 32'h0000_8001, 6'b100000);
      // R7: overflow held at larger counts, both values
      run_op("R7", 2'd0, 2'd2, 5'd2, 32'h4000_0000, 6'b100000);
      run_op("R7", 2'd1, 2'd0, 5'd7, 32'h0000_0080, 6'b000000);
      // R2 right after a nonzero op with different flags
      run_op("R2", 2'd0, 2'd2, 5'd0, 32'h1234_5678, 6'b010101);
      // R8 / R9: aux set, parity and sign
      run_op("R8", 2'd1, 2'd2, 5'd4, 32'h0000_0030, 6'b000000);
      run_op("R9", 2'd0, 2'd0, 5'd1, 32'h0000_0041, 6'b000000);
      run_op("R9", 2'd2, 2'd1, 5'd3, 32'h0000_8000, 6'b000000);

      // sweep: every width, op, count, with random operands and flags
      for (int w = 0; w < 3; w++)
         for (int op = 0; op < 3; op++)
            for (int c = 0; c < 32; c++)
               for (int r = 0; r < 3; r++)
                  run_op(tag_for(2'(op), 5'(c)), 2'(op), 2'(w), 5'(c), $urandom, 6'($urandom));

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule